// File: doc/BRIEF.md
# Ethernet MAC Pause Flow Controller

This block produces the transmit-side flow control requests of an Ethernet MAC. A single 32-bit control word holds two 16-bit values: a re-send interval and a pause quanta. When a flow control request starts in full duplex, the block raises a one-cycle pulse that asks the transmitter to emit a PAUSE control frame. The pulse carries the quanta value. While the request is held, the block repeats the pulse each time the interval expires.

In half duplex the same request instead holds a backpressure output high for a number of cycles equal to the quanta value. One 16-bit counter serves both roles. Its live value appears on a read-only status word, so software can watch the re-send timer or the backpressure timer progress. Frame assembly and the transmit datapath sit outside this block.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `send_pause`, `backpressure`, `pause_quanta` and `status` are all zero, and both configuration fields are zero.
- R2: A cycle with `cfg_we` high loads the interval from `cfg_wdata[15:0]` and the quanta from `cfg_wdata[31:16]`. The new values are used from the next clock edge onward, including by a sequence that is already running.
- R3: When `fc_req` is sampled high after being low and `full_duplex` is 1, `send_pause` is high for exactly one cycle after that clock edge. `pause_quanta` then holds the configured quanta value.
- R4: In full duplex with the request held and a non-zero interval N, `send_pause` repeats every N cycles. After each pulse `status[15:0]` restarts at 0 and climbs by one per cycle. A new pulse is issued when the next count would reach or pass N.
- R5: In full duplex with an interval of zero, a request produces exactly one pulse, and `status` stays 0.
- R6: When `fc_req` is sampled rising with `full_duplex` at 0 and the quanta is Q > 0, `backpressure` goes high after that edge and stays high for exactly Q cycles. `status[15:0]` climbs to Q and then holds. Backpressure stays low until the next rising edge of the request.
- R7: In half duplex with a quanta of zero, a request produces no backpressure.
- R8: A cycle with `fc_req` sampled low clears the counter and suppresses any pulse or backpressure on the next cycle. This holds even when that cycle coincides with an interval expiry.
- R9: The duplex mode is captured at the rising edge of the request and held for that request. `send_pause` and `backpressure` are never high together.
- R10: `status[31:16]` always reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: [15:0] interval, [31:16] quanta |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| fc_req | input | 1 | Flow control request level |
| send_pause | output | 1 | One-cycle request to transmit a PAUSE frame |
| pause_quanta | output | 16 | Quanta value for the PAUSE frame timer field |
| backpressure | output | 1 | Half-duplex backpressure |
| status | output | 32 | Live counter in [15:0], zero in [31:16] |

## Verification
Two events can land in the same cycle. The first is the full-duplex interval expiring while the request is being withdrawn. The bench releases `fc_req` exactly one cycle before a re-send would occur, so the drop and the expiry are sampled at the same edge. It then checks that no pulse is issued and the counter clears. The second is a configuration write arriving while a sequence is counting. The bench rewrites the interval mid-run and judges both cases against a behavioural model that applies the write only after the edge that samples it.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int CNT_W = 16;

    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_FULL = 1'b1
    } duplex_e;
endpackage

// File: rtl/pfc_cfg_reg.sv
module pfc_cfg_reg #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   interval,
    output logic [W-1:0]   quanta
);
    typedef struct packed {
        logic [W-1:0] interval;
        logic [W-1:0] quanta;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.interval = wdata[W-1:0];
            s_d.quanta   = wdata[2*W-1:W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign interval = s_q.interval;
    assign quanta   = s_q.quanta;

    // R2: a write is visible on the fields one edge later
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (interval == $past(wdata[W-1:0]) && quanta == $past(wdata[2*W-1:W])));
endmodule

// File: rtl/pfc_req_edge.sv
module pfc_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic start
);
    logic prev_d, prev_q;

    always_comb prev_d = req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign start = req & ~prev_q;
endmodule

// File: rtl/pfc_engine.sv
module pfc_engine
    import pfc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fc_req,
    input  logic         req_start,
    input  logic         full_duplex,
    input  logic [W-1:0] interval,
    input  logic [W-1:0] quanta,
    output logic         send_pause,
    output logic [W-1:0] pause_quanta,
    output logic         backpressure,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        duplex_e      mode;
        logic         pulse;
        logic         bp;
        logic [W-1:0] qout;
    } eng_t;

    eng_t s_d, s_q;
    logic [W:0] nxt_cnt;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        nxt_cnt   = {1'b0, s_q.cnt} + {{W{1'b0}}, 1'b1};
        if (!fc_req) begin
            s_d.cnt = '0;
            s_d.run = 1'b0;
            s_d.bp  = 1'b0;
        end else if (req_start) begin
            s_d.cnt = '0;
            if (full_duplex) begin
                s_d.mode  = MODE_FULL;
                s_d.pulse = 1'b1;
                s_d.qout  = quanta;
                s_d.run   = |interval;
                s_d.bp    = 1'b0;
            end else begin
                s_d.mode = MODE_HALF;
                s_d.run  = |quanta;
                s_d.bp   = |quanta;
            end
        end else if (s_q.run) begin
            if (s_q.mode == MODE_FULL) begin
                if (nxt_cnt >= {1'b0, interval}) begin
                    s_d.pulse = 1'b1;
                    s_d.qout  = quanta;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = nxt_cnt[W-1:0];
                end
            end else begin
                s_d.cnt = nxt_cnt[W-1:0];
                if (nxt_cnt >= {1'b0, quanta}) begin
                    s_d.run = 1'b0;
                    s_d.bp  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign send_pause   = s_q.pulse;
    assign pause_quanta = s_q.qout;
    assign backpressure = s_q.bp;
    assign count        = s_q.cnt;

    // R3: every pulse follows a cycle with the request active
    p_pulse_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        send_pause |-> $past(fc_req));
    // R3: a full-duplex request edge always yields a pulse
    p_fd_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && full_duplex) |=> send_pause);
    // R6: a half-duplex edge with non-zero quanta raises backpressure
    p_hd_start_bp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !full_duplex && quanta != '0) |=> backpressure);
    // R8: withdrawing the request clears everything
    p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_req |=> (count == '0 && !send_pause && !backpressure));
    // R9: the two outputs are exclusive
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_pause && backpressure));
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
    parameter int CNT_W = pfc_pkg::CNT_W,
    localparam int WORD_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              full_duplex,
    input  logic              fc_req,
    output logic              send_pause,
    output logic [CNT_W-1:0]  pause_quanta,
    output logic              backpressure,
    output logic [WORD_W-1:0] status
);
    logic [CNT_W-1:0] interval, quanta, count;
    logic             req_start;

    pfc_cfg_reg #(.W(CNT_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .interval(interval), .quanta(quanta)
    );

    pfc_req_edge i_edge (
        .clk(clk), .rst_n(rst_n), .req(fc_req), .start(req_start)
    );

    pfc_engine #(.W(CNT_W)) i_eng (
        .clk(clk), .rst_n(rst_n), .fc_req(fc_req), .req_start(req_start),
        .full_duplex(full_duplex), .interval(interval), .quanta(quanta),
        .send_pause(send_pause), .pause_quanta(pause_quanta),
        .backpressure(backpressure), .count(count)
    );

    // R10: upper half of the status word is zero
    assign status = {{(WORD_W-CNT_W){1'b0}}, count};
endmodule

// File: tb/test_pause_flow_ctrl.sv
module test_pause_flow_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        full_duplex = 1'b0;
    logic        fc_req = 1'b0;
    logic        send_pause, backpressure;
    logic [15:0] pause_quanta;
    logic [31:0] status;

    int total = 0, fails = 0;
    int pulse_cnt = 0, bp_cnt = 0;
    string cur_req = "R1";

    pause_flow_ctrl i_pause_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .full_duplex(full_duplex), .fc_req(fc_req), .send_pause(send_pause),
        .pause_quanta(pause_quanta), .backpressure(backpressure), .status(status)
    );

    always #10 clk = ~clk;

    // behavioural reference
    int m_int = 0, m_q = 0, m_cnt = 0, m_qout = 0;
    bit m_run = 0, m_fd = 0, m_bp = 0, m_pulse = 0, m_prev = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_int = 0; m_q = 0; m_cnt = 0; m_qout = 0;
            m_run = 0; m_fd = 0; m_bp = 0; m_pulse = 0; m_prev = 0;
        end else begin
            m_pulse = 0;
            if (!fc_req) begin
                m_cnt = 0; m_run = 0; m_bp = 0;
            end else if (!m_prev) begin
                m_cnt = 0; m_fd = full_duplex;
                if (full_duplex) begin
                    m_pulse = 1; m_qout = m_q; m_run = (m_int != 0); m_bp = 0;
                end else begin
                    m_run = (m_q != 0); m_bp = m_run;
                end
            end else if (m_run) begin
                if (m_fd) begin
                    if (m_cnt + 1 >= m_int) begin
                        m_pulse = 1; m_qout = m_q; m_cnt = 0;
                    end else m_cnt = m_cnt + 1;
                end else begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt >= m_q) begin m_run = 0; m_bp = 0; end
                end
            end
            if (cfg_we) begin
                m_int = int'(cfg_wdata[15:0]);
                m_q   = int'(cfg_wdata[31:16]);
            end
            m_prev = fc_req;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(send_pause == m_pulse, {cur_req, " send_pause"}, send_pause, m_pulse);
            check(backpressure == m_bp, {cur_req, " backpressure"}, backpressure, m_bp);
            check(int'(status) == m_cnt, {cur_req, " status"}, int'(status), m_cnt);
            check(int'(pause_quanta) == m_qout, {cur_req, " quanta"}, int'(pause_quanta), m_qout);
            if (send_pause) pulse_cnt++;
            if (backpressure) bp_cnt++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int iv, input int qv);
        cfg_wdata = {qv[15:0], iv[15:0]};
        cfg_we = 1'b1;
        cycles(1);
        cfg_we = 1'b0;
        cycles(1);
    endtask

    task automatic clear_counts;
        pulse_cnt = 0; bp_cnt = 0;
    endtask

    initial begin
        #(20 * 50000);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check(send_pause == 0 && backpressure == 0, "R1 outputs", send_pause, 0);
        check(status == 0 && pause_quanta == 0, "R1 status", int'(status), 0);

        // R2 + R3 + R4: full duplex, interval 5
        cur_req = "R2";
        write_cfg(5, 16'h1234);
        cur_req = "R4";
        full_duplex = 1'b1; clear_counts();
        fc_req = 1'b1; cycles(16); fc_req = 1'b0; cycles(4);
        check(pulse_cnt == 4, "R4 pulse count", pulse_cnt, 4);
        check(pause_quanta == 16'h1234, "R3 quanta", int'(pause_quanta), 'h1234);

        // R5: interval zero
        cur_req = "R5";
        write_cfg(0, 16'h0042); clear_counts();
        fc_req = 1'b1; cycles(10);
        check(status == 0, "R5 status", int'(status), 0);
        fc_req = 1'b0; cycles(3);
        check(pulse_cnt == 1, "R5 pulse count", pulse_cnt, 1);

        // R6 + R10: half duplex, quanta 7
        cur_req = "R6";
        write_cfg(3, 7); full_duplex = 1'b0; clear_counts();
        fc_req = 1'b1; cycles(12);
        check(status[15:0] == 7, "R6 status hold", int'(status), 7);
        check(status[31:16] == 0, "R10 upper bits", int'(status[31:16]), 0);
        fc_req = 1'b0; cycles(3);
        check(bp_cnt == 7, "R6 bp cycles", bp_cnt, 7);
        check(pulse_cnt == 0, "R9 no pulse in half duplex", pulse_cnt, 0);

        // R7: half duplex, quanta 0
        cur_req = "R7";
        write_cfg(3, 0); clear_counts();
        fc_req = 1'b1; cycles(8); fc_req = 1'b0; cycles(3);
        check(bp_cnt == 0, "R7 bp cycles", bp_cnt, 0);

        // R8: drop coincides with interval expiry
        cur_req = "R8";
        write_cfg(4, 9); full_duplex = 1'b1; clear_counts();
        fc_req = 1'b1; cycles(8); fc_req = 1'b0; cycles(1);
        check(status == 0 && !send_pause, "R8 cleared", int'(status), 0);
        cycles(3);
        check(pulse_cnt == 2, "R8 pulse count", pulse_cnt, 2);

        // R9: mode captured at request edge
        cur_req = "R9";
        write_cfg(3, 5); full_duplex = 1'b1; clear_counts();
        fc_req = 1'b1; cycles(2); full_duplex = 1'b0; cycles(8);
        fc_req = 1'b0; cycles(3);
        check(pulse_cnt == 4, "R9 pulse count", pulse_cnt, 4);
        check(bp_cnt == 0, "R9 no backpressure", bp_cnt, 0);

        // R2: rewrite interval while counting
        cur_req = "R2";
        write_cfg(10, 3); full_duplex = 1'b1;
        fc_req = 1'b1; cycles(3);
        write_cfg(2, 6);
        cycles(6); fc_req = 1'b0; cycles(3);
        check(pause_quanta == 6, "R2 new quanta", int'(pause_quanta), 6);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule